// File: doc/BRIEF.md
# Configurable PCM Serial Audio Transmitter

This block turns parallel left and right audio samples into a three-wire serial PCM stream. The three wires are a bit clock, a word-select clock and a serial data line. The bit clock is divided down from the system clock. Serial data and word select change only on the falling edge of the bit clock, so a receiver samples them on the rising edge. One frame is a left slot followed by a right slot.

The sample pair is taken through a valid/ready handshake once per frame, just before the left slot starts. If no pair is offered, the last pair is sent again. A configuration word sets four things: the precision (16, 18, 20 or 24 bits), the bit order, the slot length (16 or 32 bit clocks) and, for 32-clock slots, where the sample sits and how the padding is filled. The configuration is sampled only at frame boundaries. A mute input zeroes the data line while both clocks keep running.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held and right after it is released, bclk_o is 0, ws_o is 1, sdata_o is 0 and in_ready is 0.
- R2: bclk_o has a period of 2*HALF_DIV system clocks, with each level held for HALF_DIV clocks. sdata_o and ws_o change only in the cycle where bclk_o falls.
- R3: ws_o is 0 during a left slot and 1 during a right slot. The first slot after reset is a left slot, and the value alternates at every slot boundary.
- R4: cfg_prec selects the precision: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. A P-bit sample is MSB-aligned in the 24-bit input and occupies bits [23:24-P].
- R5: With cfg_long_slot=0, every slot lasts 16 bit clocks and carries input bits [23:8], whatever the precision.
- R6: With cfg_long_slot=1, every slot lasts 32 bit clocks and carries the P sample bits plus 32-P padding bits.
- R7: With cfg_lsb_first=0 the sample bits go out MSB first. With cfg_lsb_first=1 they go out LSB first.
- R8: In a 32-clock slot, cfg_late_just=0 places the sample in the first P bit clocks, and cfg_late_just=1 places it in the last P bit clocks.
- R9: In a 32-clock slot, padding bits are 0 when cfg_sign_fill=0 and equal input bit 23 when cfg_sign_fill=1.
- R10: in_ready pulses high for one system clock in the cycle before each left slot starts. If in_valid is high in that cycle, the pair is taken for the frame. Otherwise the previous pair is sent again; before any transfer, that pair is all zeros.
- R11: mute is sampled at every falling edge of bclk_o. While it is set, the data bit that starts there is 0, and bclk_o and ws_o keep running.
- R12: All cfg_* inputs are sampled only in the cycle where in_ready is high. Changes at any other time have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair accepted in this cycle if in_valid is high |
| in_left | input | 24 | Left sample, MSB-aligned |
| in_right | input | 24 | Right sample, MSB-aligned |
| cfg_prec | input | 2 | Precision code |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_long_slot | input | 1 | 32-clock slots when set |
| cfg_late_just | input | 1 | Sample at end of long slot when set |
| cfg_sign_fill | input | 1 | Pad with sign copies when set |
| mute | input | 1 | Force data bits to zero |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 for left and 1 for right |
| sdata_o | output | 1 | Serial data |

## Verification
Some properties are checked by assertions on every cycle:
- the line and word select move only on a falling bit clock;
- ready is a one-cycle pulse followed by a left slot;
- mute gives a zero bit;
- the slot position stays within the slot length;
- the latched configuration changes only at a frame boundary.

The content of each slot can only be shown by the bench. It compares every captured slot against a model slot built from the pair and the configuration that were current at the handshake. This covers precision, bit order, justification, fill, repetition of a stale pair, and configuration scrambled in the middle of a frame.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SMP_W   = 24;
  localparam int SLOT_S  = 16;
  localparam int SLOT_L  = 32;
  localparam int POS_W   = $clog2(SLOT_L);
  localparam int IDX_W   = POS_W + 1;

  typedef enum logic [1:0] {
    PREC_16 = 2'd0,
    PREC_18 = 2'd1,
    PREC_20 = 2'd2,
    PREC_24 = 2'd3
  } prec_e;

  typedef struct packed {
    prec_e prec;
    logic  lsb_first;
    logic  long_slot;
    logic  late_just;
    logic  sign_fill;
  } cfg_t;

  function automatic logic [IDX_W-1:0] prec_bits(prec_e p);
    case (p)
      PREC_16: prec_bits = IDX_W'(16);
      PREC_18: prec_bits = IDX_W'(18);
      PREC_20: prec_bits = IDX_W'(20);
      default: prec_bits = IDX_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign bclk      = bclk_q;
  assign fall_tick = wrap & bclk_q;

  AST_BCLK_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bclk_q) && !$past(rst)) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_tick,
  input  cfg_t             cfg_in,
  output logic             frame_start,
  output logic [POS_W-1:0] pos_n,
  output logic             right_n,
  output cfg_t             cfg_n
);
  logic [POS_W-1:0] pos_q;
  logic             right_q;
  cfg_t             cfg_q;
  logic [POS_W-1:0] pos_last;
  logic             slot_end;

  assign pos_last    = cfg_q.long_slot ? POS_W'(SLOT_L - 1) : POS_W'(SLOT_S - 1);
  assign slot_end    = (pos_q == pos_last);
  assign frame_start = slot_end & right_q;

  always_comb begin
    pos_n   = slot_end ? '0 : pos_q + POS_W'(1);
    right_n = slot_end ? ~right_q : right_q;
    cfg_n   = frame_start ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= POS_W'(SLOT_S - 1);
      right_q <= 1'b1;
      cfg_q   <= '0;
    end else if (fall_tick) begin
      pos_q   <= pos_n;
      right_q <= right_n;
      cfg_q   <= cfg_n;
    end
  end

  AST_POS_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    pos_q <= pos_last); // R6

  AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cfg_q) && !$past(rst)) |-> ($past(fall_tick) && $past(frame_start))); // R12

  AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (fall_tick && slot_end) |=> (right_q != $past(right_q))); // R3
endmodule

// File: rtl/pcm_bit_pick.sv
module pcm_bit_pick
  import pcm_tx_pkg::*;
(
  input  cfg_t             cfg,
  input  logic [POS_W-1:0] pos,
  input  logic [SMP_W-1:0] sample,
  input  logic             mute,
  output logic             bit_o
);
  logic [IDX_W-1:0] width;
  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] q;
  logic [IDX_W-1:0] k;
  logic [IDX_W-1:0] idx;
  logic             in_word;
  logic             pad;

  always_comb begin
    width   = cfg.long_slot ? prec_bits(cfg.prec) : IDX_W'(SLOT_S);
    off     = (cfg.long_slot && cfg.late_just) ? (IDX_W'(SLOT_L) - width) : '0;
    q       = {1'b0, pos} - off;
    in_word = ({1'b0, pos} >= off) && (q < width);
    k       = cfg.lsb_first ? q : (width - IDX_W'(1) - q);
    idx     = IDX_W'(SMP_W) - width + k;
    pad     = cfg.sign_fill & sample[SMP_W-1];
    if (mute)         bit_o = 1'b0;
    else if (in_word) bit_o = sample[idx[POS_W-1:0]];
    else              bit_o = pad;
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] in_left,
  input  logic [23:0] in_right,
  input  logic [1:0]  cfg_prec,
  input  logic        cfg_lsb_first,
  input  logic        cfg_long_slot,
  input  logic        cfg_late_just,
  input  logic        cfg_sign_fill,
  input  logic        mute,
  output logic        bclk_o,
  output logic        ws_o,
  output logic        sdata_o
);
  logic             fall_tick;
  logic             frame_start;
  logic [POS_W-1:0] pos_n;
  logic             right_n;
  cfg_t             cfg_in;
  cfg_t             cfg_n;
  logic [SMP_W-1:0] left_q, right_q;
  logic [SMP_W-1:0] left_n, right_s_n;
  logic [SMP_W-1:0] cur_sample;
  logic             take;
  logic             next_bit;
  logic             ws_q, sdata_q;

  assign cfg_in = '{prec: prec_e'(cfg_prec), lsb_first: cfg_lsb_first,
                    long_slot: cfg_long_slot, late_just: cfg_late_just,
                    sign_fill: cfg_sign_fill};

  pcm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk_o),
    .fall_tick (fall_tick)
  );

  pcm_slot_ctrl u_slot (
    .clk         (clk),
    .rst         (rst),
    .fall_tick   (fall_tick),
    .cfg_in      (cfg_in),
    .frame_start (frame_start),
    .pos_n       (pos_n),
    .right_n     (right_n),
    .cfg_n       (cfg_n)
  );

  assign in_ready   = fall_tick & frame_start;
  assign take       = in_ready & in_valid;
  assign left_n     = take ? in_left  : left_q;
  assign right_s_n  = take ? in_right : right_q;
  assign cur_sample = right_n ? right_s_n : left_n;

  pcm_bit_pick u_pick (
    .cfg    (cfg_n),
    .pos    (pos_n),
    .sample (cur_sample),
    .mute   (mute),
    .bit_o  (next_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      ws_q    <= 1'b1;
      sdata_q <= 1'b0;
    end else if (fall_tick) begin
      left_q  <= left_n;
      right_q <= right_s_n;
      ws_q    <= right_n;
      sdata_q <= next_bit;
    end
  end

  assign ws_o    = ws_q;
  assign sdata_o = sdata_q;

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdata_o) && !$past(rst)) |-> $fell(bclk_o)); // R2

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ws_o) && !$past(rst)) |-> $fell(bclk_o)); // R3

  AST_READY_THEN_LEFT: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (!ws_o && $fell(bclk_o))); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready); // R10

  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mute && fall_tick) |=> !sdata_o); // R11
endmodule

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
  localparam int HALF = 2;
  localparam int N_FRAMES = 80;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic in_ready;
  logic [23:0] in_left, in_right;
  logic [1:0] cfg_prec;
  logic cfg_lsb_first, cfg_long_slot, cfg_late_just, cfg_sign_fill;
  logic mute;
  logic bclk_o, ws_o, sdata_o;

  always #2 clk = ~clk;

  pcm_serial_tx #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .cfg_prec(cfg_prec),
    .cfg_lsb_first(cfg_lsb_first), .cfg_long_slot(cfg_long_slot),
    .cfg_late_just(cfg_late_just), .cfg_sign_fill(cfg_sign_fill),
    .mute(mute), .bclk_o(bclk_o), .ws_o(ws_o), .sdata_o(sdata_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // frame expectation, captured at the handshake cycle
  logic [1:0]  f_prec;
  logic        f_lsb, f_long, f_late, f_fill, f_mute;
  logic [23:0] f_l, f_r;
  logic [23:0] hold_l = '0, hold_r = '0;
  logic [63:0] act_bits, act_ws;
  int nbit;
  bit active;

  task automatic check(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic int prec_w(logic [1:0] c);
    // R4: code to width
    case (c)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  // Slot in time order: element t of the result is the t-th bit sent.
  function automatic logic [31:0] model_slot(logic [23:0] s, logic [1:0] prec, logic lsb,
                                             logic lng, logic late, logic fill, logic mu);
    logic [31:0] v;
    int len, w, start;
    logic padv;
    len = lng ? 32 : 16;
    w   = lng ? prec_w(prec) : 16;          // R5: short slot keeps top 16 bits
    start = (lng && late) ? len - w : 0;    // R8
    padv = fill & s[23];                    // R9
    v = '0;
    for (int t = 0; t < len; t++) v[t] = padv;
    for (int t = 0; t < w; t++)
      v[start + t] = lsb ? s[24 - w + t] : s[23 - t];  // R7
    if (mu) v = '0;                         // R11
    return v;
  endfunction

  task automatic check_frame();
    int len;
    logic [31:0] al, ar, el, er;
    bit ws_ok;
    string tag;
    len = f_long ? 32 : 16;
    al = '0; ar = '0; ws_ok = 1;
    for (int p = 0; p < len; p++) begin
      al[p] = act_bits[p];
      ar[p] = act_bits[len + p];
      if (act_ws[p] !== 1'b0 || act_ws[len + p] !== 1'b1) ws_ok = 0;
    end
    el = model_slot(f_l, f_prec, f_lsb, f_long, f_late, f_fill, f_mute);
    er = model_slot(f_r, f_prec, f_lsb, f_long, f_late, f_fill, f_mute);
    tag = f_mute ? "R11" : (!f_long ? "R5" : "R6");
    // R4 R7 R8 R9 R10 R12 are also covered by these slot comparisons
    check(nbit == 2 * len, tag, "bits per frame", 32'(nbit), 32'(2 * len));
    check(al === el, tag, "left slot", al, el);
    check(ar === er, tag, "right slot", ar, er);
    check(ws_ok, "R3", "word select level per slot", {31'b0, ws_ok}, 32'd1);
  endtask

  task automatic pick_frame(int f);
    logic v;
    if (f < 16) begin
      v = (f != 2 && f != 9);           // R10: frames without a new pair
      in_left  = 24'h9A5C3E ^ 24'(f * 24'h010203);
      in_right = 24'h35A1F7 ^ 24'(f * 24'h030201);
      cfg_prec = 2'(f);                 // R4
      cfg_long_slot = (f >= 4);
      cfg_lsb_first = f[0] ^ f[2];      // R7
      cfg_late_just = f[2];             // R8
      cfg_sign_fill = f[3];             // R9
      mute = (f == 5);                  // R11
    end else begin
      v = ($urandom % 4) != 0;
      in_left  = 24'($urandom);
      in_right = 24'($urandom);
      cfg_prec = 2'($urandom);
      cfg_long_slot = 1'($urandom);
      cfg_lsb_first = 1'($urandom);
      cfg_late_just = 1'($urandom);
      cfg_sign_fill = 1'($urandom);
      mute = ($urandom % 8) == 0;
    end
    in_valid = v;
    if (v) begin hold_l = in_left; hold_r = in_right; end
    f_l = hold_l; f_r = hold_r;
    f_prec = cfg_prec; f_lsb = cfg_lsb_first; f_long = cfg_long_slot;
    f_late = cfg_late_just; f_fill = cfg_sign_fill; f_mute = mute;
  endtask

  initial begin : main
    int frames, since_rise, per_bad, edge_bad;
    bit seen_rise;
    logic pb, pd, pw;
    void'($urandom(32'h5EED_0417));
    rst = 1; in_valid = 0; in_left = '0; in_right = '0; cfg_prec = '0;
    cfg_lsb_first = 0; cfg_long_slot = 0; cfg_late_just = 0; cfg_sign_fill = 0; mute = 0;
    repeat (5) @(negedge clk);
    check(bclk_o === 0 && ws_o === 1 && sdata_o === 0 && in_ready === 0, "R1",
          "outputs in reset", {28'b0, bclk_o, ws_o, sdata_o, in_ready}, 32'h4);
    rst = 0;
    @(negedge clk);
    check(bclk_o === 0 && ws_o === 1 && sdata_o === 0 && in_ready === 0, "R1",
          "outputs after release", {28'b0, bclk_o, ws_o, sdata_o, in_ready}, 32'h4);
    frames = 0; since_rise = 0; per_bad = 0; edge_bad = 0; seen_rise = 0;
    active = 0; nbit = 0; act_bits = '0; act_ws = '0;
    pb = bclk_o; pd = sdata_o; pw = ws_o;
    while (frames < N_FRAMES) begin
      @(negedge clk);
      since_rise++;
      if ((sdata_o !== pd || ws_o !== pw) && !(pb === 1'b1 && bclk_o === 1'b0)) edge_bad++;
      if (bclk_o === 1'b1 && pb === 1'b0) begin
        if (seen_rise && since_rise != 2 * HALF) per_bad++;
        seen_rise = 1; since_rise = 0;
        if (active && nbit < 64) begin
          act_bits[nbit] = sdata_o;
          act_ws[nbit]   = ws_o;
          nbit++;
        end
      end
      pb = bclk_o; pd = sdata_o; pw = ws_o;
      if (in_ready === 1'b1) begin
        if (active) check_frame();
        pick_frame(frames);
        frames++;
        active = 1; nbit = 0; act_bits = '0; act_ws = '0;
      end else begin
        // R12: configuration and pair inputs scrambled between handshakes
        if (($urandom % 16) == 0) begin
          cfg_prec = 2'($urandom); cfg_long_slot = 1'($urandom);
          cfg_lsb_first = 1'($urandom); cfg_late_just = 1'($urandom);
          cfg_sign_fill = 1'($urandom);
        end
        in_valid = 1'($urandom);
        in_left = 24'($urandom); in_right = 24'($urandom);
      end
    end
    check(per_bad == 0, "R2", "bit clock period violations", 32'(per_bad), 32'd0);
    check(edge_bad == 0, "R2", "changes away from falling edge", 32'(edge_bad), 32'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule